// File: doc/BRIEF.md
# Victim Buffer Miss Controller

This controller sits between a first-level data cache and a second-level cache that holds only lines absent from the first level. When the first level misses, the controller fetches the requested line from the second level over a single 64-bit port. The line the first level is evicting arrives with the same request and is parked in a small victim buffer. Parking takes place while the fetch is under way, so it adds no time. Parked victims are later written into the second level, because the second level is where evicted lines are kept.

The block produces a cycle-exact miss latency. A miss normally takes 11 cycles to its first fill word: 3 cycles to detect the miss and 8 cycles of second-level access. A miss that brings a victim while all eight buffer slots are occupied takes longer. The oldest parked line is first written out in 8 beats, then the port waits 2 cycles to turn around, and then the 8-cycle refill runs, giving 21 cycles. A miss to a line that is still parked is served from the buffer after the 3 detect cycles, with no second-level traffic. When no miss is in progress, the buffer writes its lines out oldest first in the background.

The requester watches `stall` and sends its next miss only once the controller is idle again.

Top module: `victim_xfer_ctrl`

## Requirements
- R1: After synchronous reset the buffer is empty and `stall`, `fill_vld`, `done` and `l2_en` are low. A first miss is therefore served from the second level in 11 cycles.
- R2: A miss that does not hit the buffer is a normal miss when either the buffer has a free slot or `evict_vld` is low. Counting the request cycle as cycle 0, a normal miss reads its line as beats 0..7 at `l2_addr = {line, beat}`. The fill beats appear on `fill_data` with `fill_vld` high in cycles 11..18, and beat j is bits [64j+63:64j] of the line.
- R3: On a normal miss with `evict_vld` high, the victim line and its address are stored in a free buffer slot at the request edge. The port makes no write during that miss.
- R4: A miss with `evict_vld` high, no buffer hit and all 8 slots full first writes the oldest parked line as 8 beats in cycles 3..10. It then waits 2 turnaround cycles and refills, with fill beats in cycles 21..28. The new victim takes the freed slot.
- R5: The port never issues a read in either of the 2 cycles that follow a write. Reads and writes never share a cycle.
- R6: A miss whose line address matches a parked line is served from the buffer. Fill beats appear in cycles 3..10, and the port makes no read and no write during the miss. The entry is then freed, and any victim sent with this miss is parked in its place.
- R7: `stall` is high from the request cycle until the cycle before the first fill beat, and low from the first fill beat on. `done` pulses for one cycle in the cycle after the eighth fill beat.
- R8: While no miss is in progress and `miss_req` is low, the buffer writes its lines into the second level oldest first, 8 beats per line. A line leaves the buffer only after its eighth beat. A request cuts a partial line short, and that line stays parked.
- R9: A line written out of the buffer is stored at `{line, beat}` in the second level. A later miss to that line returns the victim's data.
- R10: `miss_req` raised while a miss is in progress is ignored: the fill data, the timing and the number of fill beats stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_req | input | 1 | First-level miss, one cycle, accepted when idle |
| miss_line | input | ADDR_W | Line address of the missing line |
| evict_vld | input | 1 | A victim line accompanies this miss |
| evict_line | input | ADDR_W | Line address of the victim |
| evict_data | input | 512 | Victim line contents, beat j in bits [64j+63:64j] |
| l2_en | output | 1 | Second-level port access this cycle |
| l2_we | output | 1 | Access is a write |
| l2_addr | output | ADDR_W+3 | {line address, beat index} |
| l2_wdata | output | 64 | Write beat |
| l2_rdata | input | 64 | Read beat, valid the cycle after a read |
| stall | output | 1 | Requester must wait for the first fill word |
| fill_vld | output | 1 | Fill beat valid |
| fill_data | output | 64 | Fill beat |
| done | output | 1 | One-cycle pulse after the last fill beat |

## Verification
The bench takes the request cycle as cycle 0 and works out the latency from its own model of the buffer: 3 cycles for a buffer hit, 21 cycles for an eviction into a full buffer, and 11 cycles for any other miss. From that latency it queues each fill beat with the exact cycle-counter value it is due on. `done` is due 8 cycles after the first beat. A monitor compares both the cycle number and the data of every beat when it appears. Port reads and writes are counted across each miss and compared with 0 or 8, depending on the miss kind. Background write-backs are predicted as 1 line per 8 idle cycles, and the logged write order is compared with the oldest-first order the model expects.

// File: rtl/victim_xfer_ctrl.sv
module victim_xfer_ctrl #(
  parameter int ADDR_W     = 20,
  parameter int BEAT_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 8,
  parameter int DETECT_CYC = 3,
  parameter int L2_LAT     = 8,
  parameter int TURN_CYC   = 2
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            miss_req,
  input  logic [ADDR_W-1:0]                               miss_line,
  input  logic                                            evict_vld,
  input  logic [ADDR_W-1:0]                               evict_line,
  input  logic [LINE_BYTES*8-1:0]                         evict_data,
  output logic                                            l2_en,
  output logic                                            l2_we,
  output logic [ADDR_W+$clog2(LINE_BYTES*8/BEAT_W)-1:0]   l2_addr,
  output logic [BEAT_W-1:0]                               l2_wdata,
  input  logic [BEAT_W-1:0]                               l2_rdata,
  output logic                                            stall,
  output logic                                            fill_vld,
  output logic [BEAT_W-1:0]                               fill_data,
  output logic                                            done
);
  localparam int LINE_W   = LINE_BYTES * 8;
  localparam int BEATS    = LINE_W / BEAT_W;
  localparam int BI       = $clog2(BEATS);
  localparam int CI       = $clog2(DEPTH + 1);
  localparam int IW       = $clog2(DEPTH);
  localparam int LAT_HIT  = DETECT_CYC;
  localparam int LAT_ROOM = DETECT_CYC + L2_LAT;
  localparam int LAT_FULL = DETECT_CYC + BEATS + TURN_CYC + L2_LAT;
  localparam int TW       = $clog2(LAT_FULL + BEATS + 1);
  localparam logic [1:0] M_ROOM = 2'd0, M_FULL = 2'd1, M_HIT = 2'd2;

  logic [ADDR_W-1:0] vb_line [DEPTH];
  logic [LINE_W-1:0] vb_data [DEPTH];
  logic [CI-1:0]     occ;
  logic              busy;
  logic [TW-1:0]     t, lat;
  logic [1:0]        mode;
  logic [IW-1:0]     hit_q, hit_idx;
  logic [ADDR_W-1:0] req_q;
  logic              stage_vld;
  logic [ADDR_W-1:0] stage_line;
  logic [LINE_W-1:0] stage_data;
  logic [BI-1:0]     dbeat, rbeat, fbeat, wbeat;
  logic [DEPTH-1:0]  hv;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign hv[gi] = (occ > CI'(gi)) && (vb_line[gi] == miss_line);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hv[i]) hit_idx = IW'(i);
  end

  wire accept   = !busy && miss_req;
  wire any_hit  = |hv;
  wire full_now = (occ == CI'(DEPTH));

  assign lat = (mode == M_HIT)  ? TW'(LAT_HIT)  :
               (mode == M_FULL) ? TW'(LAT_FULL) : TW'(LAT_ROOM);

  wire rd = busy && (mode != M_HIT) && (t >= lat - TW'(1)) && (t < lat + TW'(BEATS - 1));
  wire fw = busy && (mode == M_FULL) && (t >= TW'(DETECT_CYC)) && (t < TW'(DETECT_CYC + BEATS));
  wire bw = !busy && !miss_req && (occ != '0);

  assign rbeat = BI'(t - lat + TW'(1));
  assign fbeat = BI'(t - lat);
  assign wbeat = fw ? BI'(t - TW'(DETECT_CYC)) : dbeat;

  assign l2_en    = rd || fw || bw;
  assign l2_we    = fw || bw;
  assign l2_addr  = rd ? {req_q, rbeat} : {vb_line[0], wbeat};
  assign l2_wdata = vb_data[0][wbeat*BEAT_W +: BEAT_W];

  assign fill_vld  = busy && (t >= lat) && (t < lat + TW'(BEATS));
  assign fill_data = (mode == M_HIT) ? vb_data[hit_q][fbeat*BEAT_W +: BEAT_W] : l2_rdata;
  assign done      = busy && (t == lat + TW'(BEATS));
  assign stall     = accept || (busy && (t < lat));

  wire bg_pop   = bw && (dbeat == BI'(BEATS - 1));
  wire full_pop = busy && (mode == M_FULL) && (t == TW'(DETECT_CYC + BEATS - 1));
  wire hit_end  = done && (mode == M_HIT);
  wire rm       = bg_pop || full_pop || hit_end;
  wire [IW-1:0] rm_idx = hit_end ? hit_q : '0;

  wire push_now   = accept && !any_hit && evict_vld && !full_now;
  wire push_stage = (full_pop || hit_end) && stage_vld;
  wire push       = push_now || push_stage;
  wire [ADDR_W-1:0] p_line = push_now ? evict_line : stage_line;
  wire [LINE_W-1:0] p_data = push_now ? evict_data : stage_data;
  wire [CI-1:0]     pos    = occ - CI'(rm);

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rm && (IW'(i) >= rm_idx) && (i < DEPTH - 1)) begin
        vb_line[i] <= vb_line[i+1];
        vb_data[i] <= vb_data[i+1];
      end
      if (push && (pos == CI'(i))) begin
        vb_line[i] <= p_line;
        vb_data[i] <= p_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ - CI'(rm) + CI'(push);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      t         <= '0;
      mode      <= M_ROOM;
      hit_q     <= '0;
      req_q     <= '0;
      stage_vld <= 1'b0;
      dbeat     <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      t          <= TW'(1);
      req_q      <= miss_line;
      hit_q      <= hit_idx;
      mode       <= any_hit ? M_HIT : (full_now && evict_vld) ? M_FULL : M_ROOM;
      stage_vld  <= evict_vld && (any_hit || full_now);
      stage_line <= evict_line;
      stage_data <= evict_data;
      dbeat      <= '0;
    end else if (busy) begin
      busy <= !done;
      t    <= done ? '0 : t + TW'(1);
      if (push_stage) stage_vld <= 1'b0;
    end else if (bw) begin
      dbeat <= dbeat + BI'(1);
    end else if (miss_req) begin
      dbeat <= '0;
    end
  end

  // R7
  fill_vs_stall_chk: assert property (@(posedge clk) disable iff (rst) fill_vld |-> !stall);
  // R7
  done_after_beat_chk: assert property (@(posedge clk) disable iff (rst) done |-> $past(fill_vld));
  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    (l2_en && !l2_we) |-> (!$past(l2_en && l2_we) && !$past(l2_en && l2_we, 2)));
  // R6
  hit_no_port_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode == M_HIT) |-> !l2_en);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !rm) |-> (occ != CI'(DEPTH)));
  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ($stable(req_q) && busy));
endmodule

// File: tb/victim_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module victim_xfer_ctrl_tb;
  localparam int AW = 20;
  localparam int LW = 512;
  localparam int NB = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic miss_req = 1'b0, evict_vld = 1'b0;
  logic [AW-1:0] miss_line = '0, evict_line = '0;
  logic [LW-1:0] evict_data = '0;
  logic l2_en, l2_we, stall, fill_vld, done;
  logic [AW+2:0] l2_addr;
  logic [63:0] l2_wdata, fill_data;
  logic [63:0] l2_rdata = '0;

  victim_xfer_ctrl u_dut (
    .clk(clk), .rst(rst), .miss_req(miss_req), .miss_line(miss_line),
    .evict_vld(evict_vld), .evict_line(evict_line), .evict_data(evict_data),
    .l2_en(l2_en), .l2_we(l2_we), .l2_addr(l2_addr), .l2_wdata(l2_wdata),
    .l2_rdata(l2_rdata), .stall(stall), .fill_vld(fill_vld),
    .fill_data(fill_data), .done(done));

  always #2 clk = ~clk;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  int rd_n = 0, wr_n = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [AW+2:0] a);
    return 64'hC3D2_0000_0000_0000 ^ 64'(a);
  endfunction

  function automatic logic [LW-1:0] evdata(input int id);
    logic [LW-1:0] d;
    for (int j = 0; j < NB; j++) d[j*64 +: 64] = 64'hE7E7_0000_0000_0000 | 64'(id << 16) | 64'(j);
    return d;
  endfunction

  logic [63:0]   l2m   [logic [AW+2:0]];
  logic [LW-1:0] refl2 [logic [AW-1:0]];
  logic [AW-1:0] vq_line[$];
  logic [LW-1:0] vq_data[$];
  logic [AW-1:0] exp_wlog[$], wlog[$];

  always @(posedge clk)
    if (l2_en) begin
      if (l2_we) l2m[l2_addr] = l2_wdata;
      else l2_rdata <= l2m.exists(l2_addr) ? l2m[l2_addr] : pat(l2_addr);
    end

  function automatic logic [63:0] exp_beat(input logic [AW-1:0] line, input int j);
    if (refl2.exists(line)) return refl2[line][j*64 +: 64];
    return pat({line, 3'(j)});
  endfunction

  typedef struct { int cyc; logic [63:0] d; string r; } item_t;
  item_t sbq[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (l2_en && l2_we) begin
        wr_n++;
        if (l2_addr[2:0] == 3'd0) wlog.push_back(l2_addr[AW+2:3]);
      end
      if (l2_en && !l2_we) rd_n++;
      if (fill_vld) begin
        if (sbq.size() == 0) chk(1'b0, "R10", "unexpected fill beat", fill_data, 64'd0);
        else begin
          item_t it;
          it = sbq.pop_front();
          chk(cyc == it.cyc, it.r, "fill beat cycle", 64'(cyc), 64'(it.cyc));
          chk(fill_data == it.d, it.r, "fill beat data", fill_data, it.d);
        end
      end
    end
  end

  task automatic miss(input logic [AW-1:0] line, input bit ev, input int evid, input bit poke);
    int hi, lat, r0, w0;
    bit full;
    string tag;
    @(negedge clk);
    hi = -1;
    foreach (vq_line[k]) if (hi < 0 && vq_line[k] == line) hi = k;
    full = (hi < 0) && ev && (vq_line.size() == 8);
    lat  = (hi >= 0) ? 3 : full ? 21 : 11;
    tag  = (hi >= 0) ? "R6" : full ? "R4" : "R2";
    for (int j = 0; j < NB; j++) begin
      item_t it;
      it.cyc = cyc + lat + j;
      it.d   = (hi >= 0) ? vq_data[hi][j*64 +: 64] : exp_beat(line, j);
      it.r   = tag;
      sbq.push_back(it);
    end
    if (hi >= 0) begin
      vq_line.delete(hi);
      vq_data.delete(hi);
    end else if (full) begin
      exp_wlog.push_back(vq_line[0]);
      refl2[vq_line[0]] = vq_data[0];
      vq_line.pop_front();
      vq_data.pop_front();
    end
    if (ev) begin
      vq_line.push_back(AW'(32'h100 + evid));
      vq_data.push_back(evdata(evid));
    end
    r0 = rd_n; w0 = wr_n;
    miss_req = 1'b1; miss_line = line;
    evict_vld = ev; evict_line = AW'(32'h100 + evid); evict_data = evdata(evid);
    #1;
    chk(stall == 1'b1, "R7", "stall in request cycle", 64'(stall), 64'd1);
    for (int n = 1; n <= lat + 8; n++) begin
      @(negedge clk);
      if (n == 1) begin miss_req = 1'b0; evict_vld = 1'b0; end
      if (poke && n == 5) begin miss_req = 1'b1; miss_line = line ^ AW'(1); end
      if (poke && n == 6) miss_req = 1'b0;
      #1;
      chk(stall == (n < lat), (poke && n == 5) ? "R10" : "R7", "stall", 64'(stall), 64'(n < lat));
      chk(done == (n == lat + 8), "R7", "done", 64'(done), 64'(n == lat + 8));
    end
    chk(rd_n - r0 == ((hi >= 0) ? 0 : 8), (hi >= 0) ? "R6" : "R2", "port reads",
        64'(rd_n - r0), 64'((hi >= 0) ? 0 : 8));
    chk(wr_n - w0 == (full ? 8 : 0), full ? "R4" : "R3", "port writes",
        64'(wr_n - w0), 64'(full ? 8 : 0));
  endtask

  task automatic idle(input int n);
    int pops;
    repeat (n) @(negedge clk);
    pops = n / 8;
    for (int k = 0; k < pops && vq_line.size() > 0; k++) begin
      exp_wlog.push_back(vq_line[0]);
      refl2[vq_line[0]] = vq_data[0];
      vq_line.pop_front();
      vq_data.pop_front();
    end
    if (vq_line.size() > 0 && (n % 8) != 0) exp_wlog.push_back(vq_line[0]);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(!stall && !fill_vld && !done && !l2_en, "R1", "idle outputs after reset",
        64'({stall, fill_vld, done, l2_en}), 64'd0);
    miss(AW'(32'h10), 1'b0, 0, 1'b0);                 // R1 R2
    for (int id = 0; id < 8; id++)
      miss(AW'(32'h20 + id), 1'b1, id, id == 2);      // R3 R10
    miss(AW'(32'h30), 1'b1, 8, 1'b0);                 // R4
    miss(AW'(32'h100), 1'b0, 0, 1'b0);                // R9
    miss(AW'(32'h103), 1'b1, 9, 1'b0);                // R6
    idle(3);
    miss(AW'(32'h101), 1'b0, 0, 1'b0);                // R8 cut-short line stays
    idle(80);
    // R8 write-back order
    chk(wlog.size() == exp_wlog.size(), "R8", "write-back count",
        64'(wlog.size()), 64'(exp_wlog.size()));
    for (int k = 0; k < wlog.size() && k < exp_wlog.size(); k++)
      chk(wlog[k] == exp_wlog[k], "R8", "write-back order", 64'(wlog[k]), 64'(exp_wlog[k]));
    miss(AW'(32'h105), 1'b0, 0, 1'b0);                // R9
    miss(AW'(32'h109), 1'b1, 10, 1'b0);               // R9 R3
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R2", "outstanding fill beats", 64'(sbq.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule